// File: doc/BRIEF.md
# Bit Test, Rotate and Shift Unit

This is a purely combinational datapath slice for the prefixed bit-manipulation group of an 8-bit processor. The sequencer gives it the operand byte, the current carry and flag byte, and the second opcode byte. It returns the new operand value, a write-back strobe and the new flag byte. The unit decodes the opcode on its own. It finds the operation class, the bit index and the register field, and hands the register field back so that the register file can be steered.

A separate mode input marks the byte as one of the four one-byte accumulator rotates. These share the rotate datapath but follow a narrower flag rule. Addressing of memory operands and indexed displacements is done outside this unit.

Top module: `bsu_top`

## Requirements
- R1: With `acc_form_i`=0, `opcode_i[7:6]` selects the class: 00 is rotate/shift, 01 is bit test, 10 is bit reset and 11 is bit set. `opcode_i[5:3]` gives the bit index (on `bit_idx_o`) and `opcode_i[2:0]` gives the register field (on `reg_sel_o`).
- R2: The rotate/shift kind is `opcode_i[5:3]`: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL, 7 SRL. RLC and RRC rotate circularly, and the bit that leaves becomes the carry.
- R3: RL and RR rotate through `carry_i`. The bit that leaves becomes the carry.
- R4: SLA shifts left and inserts 0. SRA shifts right and keeps bit 7. SRL shifts right and inserts 0. SLL shifts left and inserts 1. In each case the carry is the bit shifted out.
- R5: The flag byte is laid out as S=7, Z=6, H=4, P=2, N=1, C=0. A prefixed rotate/shift sets S to result bit 7 and Z when the result is 0. It clears H and N, sets P when the result has an even number of ones, and sets C to the bit shifted out. Bits 5 and 3 are copied from `flags_i`.
- R6: With `acc_form_i`=1, opcodes 0x07, 0x0F, 0x17 and 0x1F perform RLC, RRC, RL and RR on the operand. These forms clear H and N, set C to the bit shifted out, and copy every other flag bit from `flags_i`.
- R7: With `acc_form_i`=1, any other opcode returns the operand unchanged, `wr_en_o`=0 and `flags_o`=`flags_i`.
- R8: Bit test sets Z to the inverse of the selected operand bit, sets H and clears N. All other flag bits, C included, are copied. The result equals the operand and `wr_en_o`=0.
- R9: Bit set and bit reset force only the selected bit to 1 or to 0, and `flags_o`=`flags_i`.
- R10: `wr_en_o` is 1 for every rotate/shift, bit set, bit reset and valid accumulator rotate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 8 | Operand byte |
| carry_i | input | 1 | Carry fed into rotate-through-carry forms |
| flags_i | input | 8 | Current flag byte |
| opcode_i | input | 8 | Second opcode byte, or the one-byte opcode in accumulator mode |
| acc_form_i | input | 1 | 1: treat opcode as a one-byte accumulator rotate |
| result_o | output | 8 | New operand value |
| wr_en_o | output | 1 | Write the result back |
| flags_o | output | 8 | New flag byte |
| bit_idx_o | output | 3 | Decoded bit index |
| reg_sel_o | output | 3 | Decoded register field |

## Verification
Some properties are checked on every input combination. Bit test never writes back and its zero flag mirrors the selected bit. Set and reset leave the flags alone and change at most one bit. Prefixed shifts clear H and N and derive S and Z from the result. Accumulator rotates keep S, Z and P. Invalid accumulator opcodes never write back.

Only the bench's vectors can show that each shift kind produces the right byte and carry, including the fill values of SRA, SLL and SRL and the use of the incoming carry by RL and RR. The same holds for the decode order of the kind field.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    CLS_SHIFT = 3'd0,
    CLS_TEST  = 3'd1,
    CLS_RES   = 3'd2,
    CLS_SET   = 3'd3,
    CLS_ACC   = 3'd4,
    CLS_NONE  = 3'd5
  } bsu_cls_e;

  typedef enum logic [2:0] {
    SH_RLC = 3'd0, SH_RRC = 3'd1, SH_RL  = 3'd2, SH_RR  = 3'd3,
    SH_SLA = 3'd4, SH_SRA = 3'd5, SH_SLL = 3'd6, SH_SRL = 3'd7
  } bsu_kind_e;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;
  localparam int OPC_W = 8;
  localparam int FLD_W = 3;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             acc_form_i,
  output bsu_cls_e         cls_o,
  output bsu_kind_e        kind_o,
  output logic [FLD_W-1:0] bit_idx_o,
  output logic [FLD_W-1:0] reg_sel_o
);
  logic acc_valid;

  assign acc_valid = (opcode_i[7:5] == 3'b000) && (opcode_i[2:0] == 3'b111);
  assign bit_idx_o = opcode_i[5:3];
  assign reg_sel_o = opcode_i[2:0];

  always_comb begin
    kind_o = bsu_kind_e'(opcode_i[5:3]);
    if (acc_form_i) begin
      kind_o = bsu_kind_e'({1'b0, opcode_i[4:3]});
      cls_o  = acc_valid ? CLS_ACC : CLS_NONE;
    end else begin
      unique case (opcode_i[7:6])
        2'b00:   cls_o = CLS_SHIFT;
        2'b01:   cls_o = CLS_TEST;
        2'b10:   cls_o = CLS_RES;
        default: cls_o = CLS_SET;
      endcase
    end
  end
endmodule

// File: rtl/bsu_shift.sv
module bsu_shift
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] operand_i,
  input  logic         carry_i,
  input  bsu_kind_e    kind_i,
  output logic [W-1:0] result_o,
  output logic         out_bit_o
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] shift_left(input logic [W-1:0] a, input logic fill);
    return {a[MSB], a[MSB-1:0], fill};
  endfunction

  function automatic logic [W:0] shift_right(input logic [W-1:0] a, input logic fill);
    return {a[0], fill, a[MSB:1]};
  endfunction

  logic [W:0] packed_res;

  always_comb begin
    unique case (kind_i)
      SH_RLC:  packed_res = shift_left(operand_i, operand_i[MSB]);
      SH_RRC:  packed_res = shift_right(operand_i, operand_i[0]);
      SH_RL:   packed_res = shift_left(operand_i, carry_i);
      SH_RR:   packed_res = shift_right(operand_i, carry_i);
      SH_SLA:  packed_res = shift_left(operand_i, 1'b0);
      SH_SRA:  packed_res = shift_right(operand_i, operand_i[MSB]);
      SH_SLL:  packed_res = shift_left(operand_i, 1'b1);
      default: packed_res = shift_right(operand_i, 1'b0);
    endcase
  end

  assign out_bit_o = packed_res[W];
  assign result_o  = packed_res[W-1:0];
endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     operand_i,
  input  logic [FLD_W-1:0] bit_idx_i,
  input  logic             set_i,
  output logic [W-1:0]     result_o,
  output logic             sel_bit_o
);
  logic [W-1:0] onehot;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign onehot[g] = (bit_idx_i == FLD_W'(g));
  end

  assign sel_bit_o = |(operand_i & onehot);
  assign result_o  = set_i ? (operand_i | onehot) : (operand_i & ~onehot);
endmodule

// File: rtl/bsu_flags.sv
module bsu_flags
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  bsu_cls_e     cls_i,
  input  logic [7:0]   flags_i,
  input  logic [W-1:0] shift_res_i,
  input  logic         out_bit_i,
  input  logic         sel_bit_i,
  output logic [7:0]   flags_o
);
  function automatic logic even_parity(input logic [W-1:0] v);
    return ~(^v);
  endfunction

  always_comb begin
    flags_o = flags_i;
    unique case (cls_i)
      CLS_SHIFT: begin
        flags_o[FL_S] = shift_res_i[W-1];
        flags_o[FL_Z] = (shift_res_i == '0);
        flags_o[FL_H] = 1'b0;
        flags_o[FL_P] = even_parity(shift_res_i);
        flags_o[FL_N] = 1'b0;
        flags_o[FL_C] = out_bit_i;
      end
      CLS_ACC: begin
        flags_o[FL_H] = 1'b0;
        flags_o[FL_N] = 1'b0;
        flags_o[FL_C] = out_bit_i;
      end
      CLS_TEST: begin
        flags_o[FL_Z] = ~sel_bit_i;
        flags_o[FL_H] = 1'b1;
        flags_o[FL_N] = 1'b0;
      end
      default: flags_o = flags_i;
    endcase
  end
endmodule

// File: rtl/bsu_top.sv
module bsu_top
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     operand_i,
  input  logic             carry_i,
  input  logic [7:0]       flags_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             acc_form_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic [7:0]       flags_o,
  output logic [FLD_W-1:0] bit_idx_o,
  output logic [FLD_W-1:0] reg_sel_o
);
  bsu_cls_e     cls;
  bsu_kind_e    kind;
  logic [W-1:0] shift_res;
  logic [W-1:0] bitop_res;
  logic         shift_out_bit;
  logic         sel_bit;

  bsu_decode u_dec (
    .opcode_i   (opcode_i),
    .acc_form_i (acc_form_i),
    .cls_o      (cls),
    .kind_o     (kind),
    .bit_idx_o  (bit_idx_o),
    .reg_sel_o  (reg_sel_o)
  );

  bsu_shift #(.W(W)) u_shift (
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .kind_i    (kind),
    .result_o  (shift_res),
    .out_bit_o (shift_out_bit)
  );

  bsu_bitop #(.W(W)) u_bitop (
    .operand_i (operand_i),
    .bit_idx_i (bit_idx_o),
    .set_i     (cls == CLS_SET),
    .result_o  (bitop_res),
    .sel_bit_o (sel_bit)
  );

  bsu_flags #(.W(W)) u_flags (
    .cls_i       (cls),
    .flags_i     (flags_i),
    .shift_res_i (shift_res),
    .out_bit_i   (shift_out_bit),
    .sel_bit_i   (sel_bit),
    .flags_o     (flags_o)
  );

  always_comb begin
    unique case (cls)
      CLS_SHIFT, CLS_ACC: result_o = shift_res;
      CLS_RES, CLS_SET:   result_o = bitop_res;
      default:            result_o = operand_i;
    endcase
  end

  assign wr_en_o = (cls != CLS_TEST) && (cls != CLS_NONE);
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0]     operand_i,
  input logic [7:0]       flags_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic             acc_form_i,
  input logic [W-1:0]     result_o,
  input logic             wr_en_o,
  input logic [7:0]       flags_o,
  input logic             sel_bit
);
  logic is_shift, is_test, is_bitwr, acc_ok;

  assign is_shift = !acc_form_i && (opcode_i[7:6] == 2'b00);
  assign is_test  = !acc_form_i && (opcode_i[7:6] == 2'b01);
  assign is_bitwr = !acc_form_i && opcode_i[7];
  assign acc_ok   = acc_form_i && (opcode_i[7:5] == 3'b000) && (opcode_i[2:0] == 3'b111);

  always_comb begin
    if (is_test) begin
      assert_test_no_write_R8: assert (!wr_en_o && result_o == operand_i);
      assert_test_zero_R8: assert (flags_o[FL_Z] == ~sel_bit && flags_o[FL_C] == flags_i[FL_C]);
    end
    if (is_bitwr) begin
      assert_bitwr_flags_R9: assert (flags_o == flags_i && $countones(result_o ^ operand_i) <= 1);
    end
    if (is_shift) begin
      assert_shift_flags_R5: assert (!flags_o[FL_H] && !flags_o[FL_N]
        && flags_o[FL_S] == result_o[W-1] && flags_o[FL_Z] == (result_o == '0));
    end
    if (acc_ok) begin
      assert_acc_keep_R6: assert (flags_o[FL_S] == flags_i[FL_S] && flags_o[FL_Z] == flags_i[FL_Z]
        && flags_o[FL_P] == flags_i[FL_P] && wr_en_o);
    end
    if (acc_form_i && !acc_ok) begin
      assert_acc_bad_R7: assert (!wr_en_o && flags_o == flags_i && result_o == operand_i);
    end
    if (!acc_form_i) begin
      assert_wr_en_R10: assert (wr_en_o == !is_test);
    end
  end
endmodule

bind bsu_top bsu_checker #(.W(W)) u_chk (
  .operand_i  (operand_i),
  .flags_i    (flags_i),
  .opcode_i   (opcode_i),
  .acc_form_i (acc_form_i),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flags_o    (flags_o),
  .sel_bit    (sel_bit)
);

// File: tb/bsu_top_tb.sv
`timescale 1ns/1ps
module bsu_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0] operand_i, flags_i, opcode_i, result_o, flags_o;
  logic       carry_i, acc_form_i, wr_en_o;
  logic [2:0] bit_idx_o, reg_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bsu_top dut_i (
    .operand_i(operand_i), .carry_i(carry_i), .flags_i(flags_i),
    .opcode_i(opcode_i), .acc_form_i(acc_form_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_o(flags_o), .bit_idx_o(bit_idx_o), .reg_sel_o(reg_sel_o)
  );

  // {acc, opcode, operand, carry, flags_in, exp_result, exp_wr, exp_flags}
  localparam int NV = 18;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h81, 1'b0, 8'h00, 8'h03, 1'b1, 8'h05}, // R2 RLC
    {1'b0, 8'h08, 8'h01, 1'b0, 8'h00, 8'h80, 1'b1, 8'h81}, // R2 RRC
    {1'b0, 8'h10, 8'h80, 1'b1, 8'h00, 8'h01, 1'b1, 8'h01}, // R3 RL
    {1'b0, 8'h18, 8'h01, 1'b0, 8'h00, 8'h00, 1'b1, 8'h45}, // R3 RR
    {1'b0, 8'h20, 8'h41, 1'b1, 8'h00, 8'h82, 1'b1, 8'h84}, // R4 SLA
    {1'b0, 8'h28, 8'h81, 1'b0, 8'h00, 8'hC0, 1'b1, 8'h85}, // R4 SRA
    {1'b0, 8'h30, 8'h00, 1'b0, 8'h00, 8'h01, 1'b1, 8'h00}, // R4 SLL
    {1'b0, 8'h38, 8'h81, 1'b0, 8'h00, 8'h40, 1'b1, 8'h01}, // R4 SRL
    {1'b0, 8'h5F, 8'h08, 1'b0, 8'hFF, 8'h08, 1'b0, 8'hBD}, // R8 bit 3 set
    {1'b0, 8'h47, 8'hFE, 1'b0, 8'h01, 8'hFE, 1'b0, 8'h51}, // R8 bit 0 clear
    {1'b0, 8'hBA, 8'hFF, 1'b0, 8'hA5, 8'h7F, 1'b1, 8'hA5}, // R9 reset 7
    {1'b0, 8'hE0, 8'h00, 1'b0, 8'h00, 8'h10, 1'b1, 8'h00}, // R9 set 4
    {1'b1, 8'h07, 8'h80, 1'b0, 8'hFF, 8'h01, 1'b1, 8'hED}, // R6 RLCA
    {1'b1, 8'h1F, 8'h01, 1'b0, 8'h00, 8'h00, 1'b1, 8'h01}, // R6 RRA
    {1'b1, 8'h17, 8'h00, 1'b1, 8'hD4, 8'h01, 1'b1, 8'hC4}, // R6 RLA
    {1'b1, 8'h0F, 8'h02, 1'b0, 8'h00, 8'h01, 1'b1, 8'h00}, // R6 RRCA
    {1'b1, 8'h3F, 8'h5A, 1'b1, 8'h3C, 8'h5A, 1'b0, 8'h3C}, // R7 invalid
    {1'b0, 8'h38, 8'h02, 1'b1, 8'h28, 8'h01, 1'b1, 8'h28}  // R5 spare bits kept
  };

  task automatic drive(input logic acc, input logic [7:0] op, input logic [7:0] a,
                       input logic c, input logic [7:0] f);
    @(posedge clk);
    acc_form_i = acc; opcode_i = op; operand_i = a; carry_i = c; flags_i = f;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    acc_form_i = 1'b0; opcode_i = 8'h00; operand_i = 8'h00; carry_i = 1'b0; flags_i = 8'h00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: all-zero inputs is RLC of 0 -> Z and P set
    check("R5 reset-state flags", {8'h0, flags_o}, 16'h0044);
    check("R10 reset-state wr_en", {15'h0, wr_en_o}, 16'h0001);
    check("R2 reset-state result", {8'h0, result_o}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][42], VEC[i][41:34], VEC[i][33:26], VEC[i][25], VEC[i][24:17]);
      check($sformatf("vector %0d result (R2/R3/R4/R6/R7/R9)", i), {8'h0, result_o}, {8'h0, VEC[i][16:9]});
      check($sformatf("vector %0d wr_en (R8/R10)", i), {15'h0, wr_en_o}, {15'h0, VEC[i][8]});
      check($sformatf("vector %0d flags (R5/R6/R8)", i), {8'h0, flags_o}, {8'h0, VEC[i][7:0]});
    end

    // R1: decoded fields
    drive(1'b0, 8'hBA, 8'h00, 1'b0, 8'h00);
    check("R1 bit index", {13'h0, bit_idx_o}, 16'd7);
    check("R1 register field", {13'h0, reg_sel_o}, 16'd2);

    // R8: bit test on every index, operand 0xA5, incoming flags all clear
    for (int b = 0; b < 8; b++) begin
      logic [7:0] opnd;
      logic zexp;
      opnd = 8'hA5;
      zexp = ((opnd >> b) & 8'h01) == 8'h00;
      drive(1'b0, 8'h40 + 8'(8 * b) + 8'h3, opnd, 1'b1, 8'h00);
      check($sformatf("R8 bit test index %0d", b), {8'h0, flags_o}, {8'h0, 1'b0, zexp, 6'b010000});
    end

    // R9: set every bit of zero, reset every bit of 0xFF
    for (int b = 0; b < 8; b++) begin
      drive(1'b0, 8'hC0 + 8'(8 * b), 8'h00, 1'b0, 8'h5A);
      check($sformatf("R9 set index %0d", b), {flags_o, result_o}, {8'h5A, 8'(1 << b)});
      drive(1'b0, 8'h80 + 8'(8 * b), 8'hFF, 1'b0, 8'h5A);
      check($sformatf("R9 reset index %0d", b), {flags_o, result_o}, {8'h5A, ~8'(1 << b)});
    end

    // R7: accumulator mode ignores a prefixed-looking opcode
    drive(1'b1, 8'hC7, 8'h33, 1'b1, 8'h81);
    check("R7 ignored opcode", {7'h0, wr_en_o, result_o}, {7'h0, 1'b0, 8'h33});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule